// File: doc/BRIEF.md
# Quadrature Position and Speed Counter

This block turns the three cleaned-up signals of an incremental rotary encoder into motion data. The two quadrature channels give the position in quarter-line steps: every rising and falling transition of either channel moves a signed position register by one. The order of the channel transitions gives the sign of each step. A direct jump across two states cannot be attributed to a direction, so it is reported and not counted.

A second counter adds up the signed steps over a fixed window of clock cycles. At the end of each window it places the saturated result on the speed output, raises a one-cycle valid pulse and starts again from zero. The once-per-revolution index channel records the position at its rising edge. A configuration input chooses whether that edge also sets the position back to zero.

The inputs must already be debounced and synchronous to `clk`. All registers use a synchronous, active-low reset. During reset the input history follows the pins, so a level present at reset release is never taken as a transition.

Top module: `qpc_counter`

## Requirements
- R1: With `{enc_a,enc_b}` stepping forward along 00→01→11→10→00, each state change pulses `cnt_strobe` one cycle later. `position` rises by one in the cycle after that strobe.
- R2: Each state change in the reverse order (00→10→11→01→00) pulses `cnt_strobe` and lowers `position` by one, with the same timing as R1.
- R3: `dir_fwd` changes only together with a `cnt_strobe`. It is 1 after a forward step and 0 after a reverse step, so a turn-around of the sequence flips it on the first step in the new direction.
- R4: A change of both channels in one cycle (00↔11 or 01↔10) pulses `seq_err` one cycle later. It gives no `cnt_strobe` and leaves `position` unchanged. Later steps are judged from the new state.
- R5: While both channels hold still, `cnt_strobe` stays low and `position` keeps its value.
- R6: `position` wraps modulo 2^32, so one reverse step from 0 gives 32'hFFFF_FFFF.
- R7: With `idx_clear_en` = 1, a rising edge on `enc_idx` loads the current position into `index_pos` and sets `position` to 0, two cycles after the edge.
- R8: With `idx_clear_en` = 0, a rising edge on `enc_idx` only loads `index_pos`. `position` keeps counting. An index level that stays high does not load `index_pos` again.
- R9: Every `GATE_CYCLES` clock cycles, counted from reset release, `speed_valid` pulses for one cycle. At that pulse `speed` shows the signed net step count of the window just ended, and `speed` changes at no other time.
- R10: The window count saturates at the most positive and most negative values of the `SPEED_W`-bit signed range.
- R11: After reset, `position`, `index_pos` and `speed` are 0, `cnt_strobe`, `seq_err` and `speed_valid` are 0, and `dir_fwd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Filtered quadrature channel A |
| enc_b | input | 1 | Filtered quadrature channel B |
| enc_idx | input | 1 | Filtered index channel, one pulse per revolution |
| idx_clear_en | input | 1 | 1: index edge also clears position; 0: capture only |
| cnt_strobe | output | 1 | One-cycle pulse per valid quarter step |
| dir_fwd | output | 1 | Direction of the latest valid step, 1 = forward |
| seq_err | output | 1 | One-cycle pulse on a two-state jump |
| position | output | POS_W (32) | Signed position, wraps around |
| index_pos | output | POS_W (32) | Position captured at the last index edge |
| speed | output | SPEED_W (16) | Saturated signed step count of the last window |
| speed_valid | output | 1 | One-cycle pulse when `speed` is updated |

## Verification
A wrong input history shows within two cycles as a missing, extra or wrongly signed strobe. It then shows one cycle later as a position that is off by one. The scoreboard catches it at the first step it affects. A wrong direction flag is visible in the same cycle as the strobe it should accompany. A fault in the window counter or the accumulator only appears at the next valid pulse: the interval between pulses is wrong, or the latched value does not match the net number of steps driven inside the window.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_FWD  = 2'd1,
    MV_REV  = 2'd2,
    MV_JUMP = 2'd3
  } move_t;

  // Successor of a two-bit quadrature state in forward order
  function automatic logic [1:0] gray_succ(input logic [1:0] s);
    case (s)
      2'b00:   gray_succ = 2'b01;
      2'b01:   gray_succ = 2'b11;
      2'b11:   gray_succ = 2'b10;
      default: gray_succ = 2'b00;
    endcase
  endfunction

  // Classify the move from one sampled channel state to the next
  function automatic move_t classify(input logic [1:0] prev, input logic [1:0] cur);
    if (cur == prev)                 classify = MV_NONE;
    else if (cur == gray_succ(prev)) classify = MV_FWD;
    else if (prev == gray_succ(cur)) classify = MV_REV;
    else                             classify = MV_JUMP;
  endfunction

endpackage

// File: rtl/qpc_edge_decode.sv
module qpc_edge_decode
  import qpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_a,
  input  logic chan_b,
  input  logic chan_idx,
  output logic step_stb,
  output logic step_fwd,
  output logic jump_err,
  output logic idx_evt
);

  logic [1:0] ab_q;
  logic       idx_q;
  move_t      mv;

  assign mv = classify(ab_q, {chan_a, chan_b});

  always_ff @(posedge clk) begin
    // input history tracks the pins through reset
    ab_q  <= {chan_a, chan_b};
    idx_q <= chan_idx;
    if (!rst_n) begin
      step_stb <= 1'b0;
      step_fwd <= 1'b1;
      jump_err <= 1'b0;
      idx_evt  <= 1'b0;
    end else begin
      step_stb <= (mv == MV_FWD) || (mv == MV_REV);
      jump_err <= (mv == MV_JUMP);
      idx_evt  <= chan_idx & ~idx_q;
      if (mv == MV_FWD)      step_fwd <= 1'b1;
      else if (mv == MV_REV) step_fwd <= 1'b0;
    end
  end

endmodule

// File: rtl/qpc_position.sv
module qpc_position #(
  parameter int POS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_stb,
  input  logic             step_fwd,
  input  logic             idx_evt,
  input  logic             clear_en,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] idx_pos
);

  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  function automatic logic [POS_W-1:0] advance(
    input logic [POS_W-1:0] p, input logic stb, input logic fwd);
    if (!stb)     advance = p;
    else if (fwd) advance = p + ONE;
    else          advance = p - ONE;
  endfunction

  logic [POS_W-1:0] pos_next;
  assign pos_next = advance(pos, step_stb, step_fwd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos     <= '0;
      idx_pos <= '0;
    end else begin
      pos <= pos_next;
      if (idx_evt) begin
        idx_pos <= pos_next;
        if (clear_en) pos <= '0;
      end
    end
  end

endmodule

// File: rtl/qpc_speed.sv
module qpc_speed #(
  parameter int SPEED_W     = 16,
  parameter int GATE_CYCLES = 50000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step_stb,
  input  logic                      step_fwd,
  output logic signed [SPEED_W-1:0] speed,
  output logic                      speed_valid
);

  localparam int GATE_W = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [GATE_W-1:0]        GATE_LAST = GATE_W'(GATE_CYCLES - 1);
  localparam logic signed [SPEED_W-1:0] SMAX = {1'b0, {(SPEED_W-1){1'b1}}};
  localparam logic signed [SPEED_W-1:0] SMIN = {1'b1, {(SPEED_W-1){1'b0}}};

  function automatic logic signed [SPEED_W-1:0] sat_step(
    input logic signed [SPEED_W-1:0] acc, input logic stb, input logic fwd);
    if (!stb)              sat_step = acc;
    else if (fwd)          sat_step = (acc == SMAX) ? SMAX : acc + 1'sb1 - 1'sb1 + SPEED_W'(1);
    else                   sat_step = (acc == SMIN) ? SMIN : acc - SPEED_W'(1);
  endfunction

  logic [GATE_W-1:0]         gate_cnt;
  logic signed [SPEED_W-1:0] acc;
  logic signed [SPEED_W-1:0] acc_next;
  logic                      gate_end;

  assign acc_next = sat_step(acc, step_stb, step_fwd);
  assign gate_end = (gate_cnt == GATE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_cnt    <= '0;
      acc         <= '0;
      speed       <= '0;
      speed_valid <= 1'b0;
    end else begin
      speed_valid <= gate_end;
      if (gate_end) begin
        gate_cnt <= '0;
        speed    <= acc_next;
        acc      <= '0;
      end else begin
        gate_cnt <= gate_cnt + GATE_W'(1);
        acc      <= acc_next;
      end
    end
  end

endmodule

// File: rtl/qpc_counter.sv
module qpc_counter #(
  parameter int POS_W       = 32,
  parameter int SPEED_W     = 16,
  parameter int GATE_CYCLES = 50000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enc_a,
  input  logic                      enc_b,
  input  logic                      enc_idx,
  input  logic                      idx_clear_en,
  output logic                      cnt_strobe,
  output logic                      dir_fwd,
  output logic                      seq_err,
  output logic [POS_W-1:0]          position,
  output logic [POS_W-1:0]          index_pos,
  output logic signed [SPEED_W-1:0] speed,
  output logic                      speed_valid
);

  // internal events, named for the checker
  logic step_stb;
  logic step_fwd;
  logic jump_err;
  logic idx_evt;

  qpc_edge_decode i_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_a   (enc_a),
    .chan_b   (enc_b),
    .chan_idx (enc_idx),
    .step_stb (step_stb),
    .step_fwd (step_fwd),
    .jump_err (jump_err),
    .idx_evt  (idx_evt)
  );

  qpc_position #(.POS_W(POS_W)) i_position (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_stb (step_stb),
    .step_fwd (step_fwd),
    .idx_evt  (idx_evt),
    .clear_en (idx_clear_en),
    .pos      (position),
    .idx_pos  (index_pos)
  );

  qpc_speed #(.SPEED_W(SPEED_W), .GATE_CYCLES(GATE_CYCLES)) i_speed (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_stb    (step_stb),
    .step_fwd    (step_fwd),
    .speed       (speed),
    .speed_valid (speed_valid)
  );

  assign cnt_strobe = step_stb;
  assign dir_fwd    = step_fwd;
  assign seq_err    = jump_err;

endmodule

// File: rtl/qpc_counter_chk.sv
module qpc_counter_chk #(
  parameter int POS_W       = 32,
  parameter int SPEED_W     = 16,
  parameter int GATE_CYCLES = 50000
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      idx_clear_en,
  input logic                      cnt_strobe,
  input logic                      dir_fwd,
  input logic                      seq_err,
  input logic                      idx_evt,
  input logic [POS_W-1:0]          position,
  input logic [POS_W-1:0]          index_pos,
  input logic signed [SPEED_W-1:0] speed,
  input logic                      speed_valid
);

  logic [31:0] since_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)           since_valid <= '0;
    else if (speed_valid) since_valid <= 32'd1;
    else                  since_valid <= since_valid + 32'd1;
  end

  AST_STEP_MOVES_POS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_strobe && !idx_evt |=> position == ($past(dir_fwd) ? $past(position) + POS_W'(1)
                                                           : $past(position) - POS_W'(1))); // R1
  AST_IDLE_HOLDS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_strobe && !idx_evt |=> $stable(position)); // R5
  AST_JUMP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_err && cnt_strobe)); // R4
  AST_DIR_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_strobe |-> $stable(dir_fwd)); // R3
  AST_INDEX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    idx_evt && idx_clear_en |=> position == '0); // R7
  AST_INDEX_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_evt |=> $stable(index_pos)); // R8
  AST_SPEED_ONLY_AT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !speed_valid |-> $stable(speed)); // R9
  AST_GATE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    speed_valid |-> since_valid == 32'(GATE_CYCLES)); // R9

endmodule

bind qpc_counter qpc_counter_chk #(
  .POS_W(POS_W), .SPEED_W(SPEED_W), .GATE_CYCLES(GATE_CYCLES)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .idx_clear_en (idx_clear_en),
  .cnt_strobe   (cnt_strobe),
  .dir_fwd      (dir_fwd),
  .seq_err      (seq_err),
  .idx_evt      (idx_evt),
  .position     (position),
  .index_pos    (index_pos),
  .speed        (speed),
  .speed_valid  (speed_valid)
);

// File: tb/test_qpc_counter.sv
module test_qpc_counter;

  localparam int PW   = 32;
  localparam int SW   = 6;
  localparam int GATE = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0, idx_clear_en = 1'b0;
  logic cnt_strobe, dir_fwd, seq_err, speed_valid;
  logic [PW-1:0] position, index_pos;
  logic signed [SW-1:0] speed;

  always #2 clk = ~clk;

  qpc_counter #(.POS_W(PW), .SPEED_W(SW), .GATE_CYCLES(GATE)) i_qpc_counter (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .idx_clear_en(idx_clear_en), .cnt_strobe(cnt_strobe), .dir_fwd(dir_fwd),
    .seq_err(seq_err), .position(position), .index_pos(index_pos),
    .speed(speed), .speed_valid(speed_valid)
  );

  typedef struct {
    logic [PW-1:0] pos;
    logic          fwd;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;
  int phase = 0;
  logic [PW-1:0] exp_pos = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] gray_of(input int ph);
    case (ph)
      0: gray_of = 2'b00;
      1: gray_of = 2'b01;
      2: gray_of = 2'b11;
      default: gray_of = 2'b10;
    endcase
  endfunction

  task automatic mv_fwd(input string tag);
    @(negedge clk);
    phase = (phase + 1) % 4;
    {enc_a, enc_b} = gray_of(phase);
    exp_pos = exp_pos + 1;
    q.push_back('{pos: exp_pos, fwd: 1'b1, tag: tag});
  endtask

  task automatic mv_rev(input string tag);
    @(negedge clk);
    phase = (phase + 3) % 4;
    {enc_a, enc_b} = gray_of(phase);
    exp_pos = exp_pos - 1;
    q.push_back('{pos: exp_pos, fwd: 1'b0, tag: tag});
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_valid();
    do @(negedge clk); while (!speed_valid);
  endtask

  // monitor: pops expectations on each strobe, checks position one cycle later
  bit pend = 0;
  exp_t cur;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pend) begin
        chk(position == cur.pos, cur.tag, "position", 64'(position), 64'(cur.pos));
        pend = 0;
      end
      if (cnt_strobe) begin
        if (q.size() == 0) begin
          chk(1'b0, "R5", "unexpected cnt_strobe", 64'd1, 64'd0);
        end else begin
          cur = q.pop_front();
          chk(dir_fwd == cur.fwd, "R3", "dir_fwd", 64'(dir_fwd), 64'(cur.fwd));
          pend = 1;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] saved;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(position == '0, "R11", "position", 64'(position), 64'd0);
    chk(index_pos == '0, "R11", "index_pos", 64'(index_pos), 64'd0);
    chk(speed == '0, "R11", "speed", 64'(speed), 64'd0);
    chk(!cnt_strobe && !seq_err && !speed_valid, "R11", "pulses",
        {61'd0, cnt_strobe, seq_err, speed_valid}, 64'd0);
    chk(dir_fwd == 1'b1, "R11", "dir_fwd", 64'(dir_fwd), 64'd1);

    // R1 forward counting
    for (int i = 0; i < 10; i++) mv_fwd("R1");
    settle();
    chk(position == 32'd10, "R1", "after 10 forward", 64'(position), 64'd10);

    // R2 reverse, R3 turn-around flips direction
    for (int i = 0; i < 3; i++) mv_rev("R2");
    settle();
    chk(position == 32'd7, "R2", "after 3 reverse", 64'(position), 64'd7);
    chk(dir_fwd == 1'b0, "R3", "dir after reversal", 64'(dir_fwd), 64'd0);

    // R4 two-state jump
    @(negedge clk);
    phase = (phase + 2) % 4;
    {enc_a, enc_b} = gray_of(phase);
    @(negedge clk);
    chk(seq_err == 1'b1, "R4", "seq_err pulse", 64'(seq_err), 64'd1);
    chk(cnt_strobe == 1'b0, "R4", "no strobe on jump", 64'(cnt_strobe), 64'd0);
    settle();
    chk(position == exp_pos, "R4", "position after jump", 64'(position), 64'(exp_pos));
    chk(dir_fwd == 1'b0, "R3", "dir held on jump", 64'(dir_fwd), 64'd0);
    mv_fwd("R4");
    settle();

    // R5 idle
    repeat (20) @(negedge clk);
    chk(position == exp_pos, "R5", "idle position", 64'(position), 64'(exp_pos));

    // R8 capture only, no retrigger while high
    idx_clear_en = 1'b0;
    @(negedge clk) enc_idx = 1'b1;
    settle();
    saved = exp_pos;
    chk(index_pos == saved, "R8", "index capture", 64'(index_pos), 64'(saved));
    chk(position == saved, "R8", "position kept", 64'(position), 64'(saved));
    mv_fwd("R8");
    mv_fwd("R8");
    settle();
    chk(index_pos == saved, "R8", "index held high", 64'(index_pos), 64'(saved));
    enc_idx = 1'b0;
    settle();

    // R7 capture and clear
    idx_clear_en = 1'b1;
    @(negedge clk) enc_idx = 1'b1;
    settle();
    chk(position == '0, "R7", "position cleared", 64'(position), 64'd0);
    chk(index_pos == exp_pos, "R7", "index capture", 64'(index_pos), 64'(exp_pos));
    exp_pos = '0;
    enc_idx = 1'b0;
    idx_clear_en = 1'b0;
    settle();

    // R6 wrap
    mv_rev("R6");
    settle();
    chk(position == 32'hFFFF_FFFF, "R6", "wrap below zero", 64'(position), 64'hFFFF_FFFF);
    mv_fwd("R6");
    settle();

    // R9 window period and signed counts
    wait_valid();
    n = 0;
    do begin @(negedge clk); n++; end while (!speed_valid);
    chk(n == GATE, "R9", "window period", 64'(n), 64'(GATE));
    for (int i = 0; i < 5; i++) mv_fwd("R9");
    wait_valid();
    chk(speed == 5, "R9", "speed forward", 64'(speed), 64'(5));
    for (int i = 0; i < 7; i++) mv_rev("R9");
    wait_valid();
    chk(speed == -7, "R9", "speed reverse", 64'(speed), 64'(-7));
    wait_valid();
    chk(speed == 0, "R9", "speed idle", 64'(speed), 64'(0));

    // R10 saturation
    for (int i = 0; i < 40; i++) mv_fwd("R10");
    wait_valid();
    chk(speed == 31, "R10", "speed max", 64'(speed), 64'(31));
    for (int i = 0; i < 40; i++) mv_rev("R10");
    wait_valid();
    chk(speed == -32, "R10", "speed min", 64'(speed), 64'(-32));

    settle();
    chk(q.size() == 0, "R1", "pending strobes", 64'(q.size()), 64'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule